// File: doc/BRIEF.md
# Multi-Rule Pseudo-Noise Ranging Chip Generator

This block produces a ranging chip stream built from six short periodic component sequences. The first is a period-2 alternating clock. The other five have coprime periods of 7, 11, 15, 19 and 23 chips. Each component keeps its own phase counter, and all counters step once per chip-enable pulse. The combined stream repeats every 2·7·11·15·19·23 = 1,009,470 chips.

A two-bit rule select chooses how the six component chips merge into the output chip. One rule is a logical OR/AND rule. The other two are signed weighted votes in which the clock component carries weight 2 or weight 4. The weighted votes use a balanced polarity set, in which three components are inverted to reduce the DC content of the output.

A synchronous start strobe zeroes every phase counter and latches the rule select. A transmit-side instance and a receive-side instance that see the same strobe therefore run in lock-step. The outputs are the combined chip, every raw component chip and every component phase, so that a downstream correlator can use them.

Top module: `pnr_seq_gen`

## Requirements
- R1: Chips are encoded 1 for +1 and 0 for -1. Bit i of comp_chip_o is entry [phase i] of component i's first-period table, listed from phase 0 onward. The tables are: c0 "10", c1 "1110010", c2 "11100010110", c3 "111100010011010", c4 "1111010100001101100", c5 "11111010110011001010000". These chips and chip_o reflect the current phases in the same cycle.
- R2: Every clock edge with chip_en_i high and start_i low advances each phase by one. Component i wraps from its period minus one to 0. The periods are 2, 7, 11, 15, 19 and 23 for i = 0..5.
- R3: A clock edge with both chip_en_i and start_i low leaves every phase unchanged.
- R4: A clock edge with start_i high sets every phase to 0, whatever the value of chip_en_i.
- R5: The rule select is latched only on an edge where start_i is high, and later changes of mode_i have no effect. The codes are 0 = OR/AND, 1 = vote with clock weight 2, 2 = vote with clock weight 4, and 3 = same as OR/AND.
- R6: In the OR/AND rule, chip_o is 1 exactly when c0 is 1, or when c1 through c5 are all 1 (raw polarity).
- R7: In the weight-2 rule, chip_o is 1 exactly when 2·s0 + s1 − s2 − s3 + s4 − s5 > 0, where si is +1 for a 1 chip and −1 for a 0 chip.
- R8: In the weight-4 rule, chip_o is 1 exactly when 4·s0 + s1 − s2 − s3 + s4 − s5 > 0.
- R9: After reset, all phases are 0 and the OR/AND rule is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Alignment strobe: zero phases, latch rule |
| mode_i | input | 2 | Combining rule select, used only with start_i |
| chip_en_i | input | 1 | Advance one chip |
| chip_o | output | 1 | Combined ranging chip |
| comp_chip_o | output | 6 | Raw component chips, bit i = component i |
| comp_phase_o | output | 6·PHASE_W | Component phases, slice i = component i |

## Verification
The bench builds the block with the default PHASE_W of 5, the smallest width that holds the longest phase of 22. Runs of several hundred chips in each rule take every component through many wraps and many different phase alignments. Each run compares all six phases, all component chips and the combined chip against a reference model on every step. Strobes that arrive together with chip enable, held-off enables, mode changes in mid-run and the reserved rule code are each driven in their own task.

// File: rtl/pnr_pkg.sv
package pnr_pkg;

    localparam int NUM_COMP = 6;
    localparam int MAX_PER  = 23;

    typedef enum logic [1:0] {
        PNR_OR_AND = 2'd0,
        PNR_VOTE2  = 2'd1,
        PNR_VOTE4  = 2'd2,
        PNR_RSVD   = 2'd3
    } pnr_mode_e;

    // Component periods, index 0 is the range clock
    localparam int COMP_PER [NUM_COMP] = '{2, 7, 11, 15, 19, 23};

    // First-period tables, bit p = chip at phase p (1 = +1)
    localparam logic [MAX_PER-1:0] COMP_TAB [NUM_COMP] = '{
        23'(2'b01),
        23'(7'b0100111),
        23'(11'b01101000111),
        23'(15'b010110010001111),
        23'(19'b0011011000010101111),
        23'b00001010011001101011111
    };

    // Components inverted in the balanced vote
    localparam logic [NUM_COMP-1:0] BAL_INV = 6'b101100;

    function automatic logic signed [4:0] pm1(input logic b);
        return b ? 5'sd1 : -5'sd1;
    endfunction

endpackage

// File: rtl/pnr_phase_ctr.sv
module pnr_phase_ctr #(
    parameter int PERIOD = 7,
    parameter int W      = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         adv,
    output logic [W-1:0] phase
);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            phase <= '0;
        end else if (adv) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);                                                   // R2
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!start && adv) |=> phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start && !adv) |=> $stable(phase));                             // R3
    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        start |=> phase == '0);                                           // R4
endmodule

// File: rtl/pnr_combiner.sv
module pnr_combiner
    import pnr_pkg::*;
(
    input  pnr_mode_e             mode,
    input  logic [NUM_COMP-1:0]   comp,
    output logic                  chip
);
    logic [NUM_COMP-1:0] bal;
    logic signed [4:0]   tail;
    logic signed [4:0]   clk_term;
    logic signed [4:0]   total;

    assign bal = comp ^ BAL_INV;

    always_comb begin
        tail = '0;
        for (int i = 1; i < NUM_COMP; i++) begin
            tail = tail + pm1(bal[i]);
        end
        clk_term = (mode == PNR_VOTE4) ? (bal[0] ? 5'sd4 : -5'sd4)
                                       : (bal[0] ? 5'sd2 : -5'sd2);
        total = clk_term + tail;
        unique case (mode)
            PNR_VOTE2, PNR_VOTE4: chip = (total > 5'sd0);
            default:              chip = comp[0] | (&comp[NUM_COMP-1:1]);
        endcase
    end
endmodule

// File: rtl/pnr_seq_gen.sv
module pnr_seq_gen
    import pnr_pkg::*;
#(
    parameter int PHASE_W = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    input  logic [1:0]                        mode_i,
    input  logic                              chip_en_i,
    output logic                              chip_o,
    output logic [NUM_COMP-1:0]               comp_chip_o,
    output logic [NUM_COMP-1:0][PHASE_W-1:0]  comp_phase_o
);
    pnr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PNR_OR_AND;
        end else if (start_i) begin
            mode_q <= pnr_mode_e'(mode_i);
        end
    end

    for (genvar g = 0; g < NUM_COMP; g++) begin : g_comp
        logic [PHASE_W-1:0] ph;
        pnr_phase_ctr #(.PERIOD(COMP_PER[g]), .W(PHASE_W)) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .start (start_i),
            .adv   (chip_en_i),
            .phase (ph)
        );
        assign comp_phase_o[g] = ph;
        assign comp_chip_o[g]  = COMP_TAB[g][ph];
    end

    pnr_combiner u_comb (
        .mode (mode_q),
        .comp (comp_chip_o),
        .chip (chip_o)
    );

    initial begin
        assert (PHASE_W >= $clog2(MAX_PER));
    end

    AST_MODE_LATCH: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(mode_q));                                    // R5
    AST_CLK_WINS: assert property (@(posedge clk) disable iff (rst)
        (mode_q inside {PNR_OR_AND, PNR_RSVD} && comp_chip_o[0]) |-> chip_o); // R6
    AST_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode_q inside {PNR_OR_AND, PNR_RSVD} && (&comp_chip_o[NUM_COMP-1:1])) |-> chip_o); // R6
    AST_ELSE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q inside {PNR_OR_AND, PNR_RSVD} && !comp_chip_o[0]
         && !(&comp_chip_o[NUM_COMP-1:1])) |-> !chip_o);                 // R6
endmodule

// File: tb/sim_pnr_seq_gen.sv
module sim_pnr_seq_gen;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [1:0]      mode_i = 2'd0;
    logic            chip_en_i = 1'b0;
    logic            chip_o;
    logic [5:0]      comp_chip_o;
    logic [5:0][4:0] comp_phase_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_ph [6];
    int m_mode;
    int per [6] = '{2, 7, 11, 15, 19, 23};
    string tab [6] = '{"10", "1110010", "11100010110", "111100010011010",
                      "1111010100001101100", "11111010110011001010000"};

    always #5 clk = ~clk;

    pnr_seq_gen u0 (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .chip_en_i    (chip_en_i),
        .chip_o       (chip_o),
        .comp_chip_o  (comp_chip_o),
        .comp_phase_o (comp_phase_o)
    );

    function automatic bit tchip(int i, int p);
        return tab[i][p] == 8'h31;
    endfunction

    function automatic bit exp_chip();
        int v;
        int s;
        bit c [6];
        for (int i = 0; i < 6; i++) c[i] = tchip(i, m_ph[i]);
        if (m_mode == 1 || m_mode == 2) begin
            v = (m_mode == 1) ? 2 : 4;
            s = v * (c[0] ? 1 : -1) + (c[1] ? 1 : -1) - (c[2] ? 1 : -1)
                - (c[3] ? 1 : -1) + (c[4] ? 1 : -1) - (c[5] ? 1 : -1);
            return s > 0;
        end
        return c[0] || (c[1] && c[2] && c[3] && c[4] && c[5]);
    endfunction

    task automatic compare(input string tag);
        for (int i = 0; i < 6; i++) begin
            checks++;
            if (comp_phase_o[i] !== 5'(m_ph[i]) || comp_chip_o[i] !== tchip(i, m_ph[i])) begin
                errors++;
                $display("FAIL %s comp%0d: phase=%0d chip=%0b expected phase=%0d chip=%0b",
                         tag, i, comp_phase_o[i], comp_chip_o[i], m_ph[i], tchip(i, m_ph[i]));
            end
        end
        checks++;
        if (chip_o !== exp_chip()) begin
            errors++;
            $display("FAIL %s chip_o=%0b expected %0b (mode %0d)", tag, chip_o, exp_chip(), m_mode);
        end
    endtask

    task automatic step(input bit st, input bit en, input int md, input string tag);
        start_i   = st;
        chip_en_i = en;
        mode_i    = 2'(md);
        @(posedge clk);
        if (st) begin
            for (int i = 0; i < 6; i++) m_ph[i] = 0;
            m_mode = md;
        end else if (en) begin
            for (int i = 0; i < 6; i++) m_ph[i] = (m_ph[i] + 1) % per[i];
        end
        @(negedge clk);
        start_i   = 1'b0;
        chip_en_i = 1'b0;
        compare(tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) m_ph[i] = 0;
        m_mode = 0;
        compare("R9");
        @(negedge clk);
        compare("R9");
    endtask

    task automatic t_or_and_run();
        // R1 R2 R6: long OR/AND run
        step(1, 0, 0, "R4");
        for (int k = 0; k < 520; k++) step(0, 1, 0, "R6");
    endtask

    task automatic t_hold();
        for (int k = 0; k < 9; k++) step(0, 1, 0, "R2");
        for (int k = 0; k < 6; k++) step(0, 0, 0, "R3");
        step(0, 1, 0, "R2");
    endtask

    task automatic t_start();
        for (int k = 0; k < 13; k++) step(0, 1, 0, "R1");
        step(1, 1, 0, "R4");
        step(0, 1, 0, "R4");
    endtask

    task automatic t_vote(input int md, input string tag);
        step(1, 0, md, "R5");
        for (int k = 0; k < 600; k++) step(0, 1, 0, tag);
    endtask

    task automatic t_mode_ignore();
        step(1, 0, 1, "R5");
        for (int k = 0; k < 60; k++) step(0, 1, 2, "R5");
        for (int k = 0; k < 30; k++) step(0, 1, 0, "R5");
        for (int k = 0; k < 30; k++) step(0, 0, 3, "R5");
    endtask

    task automatic t_reserved();
        step(1, 0, 3, "R5");
        m_mode = 0;
        for (int k = 0; k < 200; k++) step(0, 1, 1, "R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_or_and_run();
        t_hold();
        t_start();
        t_vote(1, "R7");
        t_vote(2, "R8");
        t_mode_ignore();
        t_reserved();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule